// File: doc/BRIEF.md
# Multi-channel timestamp assembler

This block turns per-channel delay-line snapshots into fixed-point event timestamps. Every clock, each channel presents a thermometer-coded tap vector: tap 0 holds the input level at the sampling instant, and higher taps hold progressively older levels. When the level at tap 0 differs from the level that sat in the last tap one clock earlier, the channel has seen an edge. The block records the edge polarity, encodes the tap position of the first transition into a raw bin index, and turns that index into a 13-bit fraction of a clock period through an external calibration table with a synchronous read port.

The timestamp has an integer part and a fraction. The integer part is a free-running coarse counter, and the fraction has 13 bits. The fine value is subtracted from the coarse count, so an edge that happened earlier in the sampling cycle gets a smaller stamp. A per-channel de-skew is then subtracted. Each event leaves the block a fixed six clocks after its sample, as a one-cycle strobe with the polarity, the stamp and the raw index. The coarse counter pulses a wrap flag each time it rolls over, and an input clears it.

Top module: `tdc_stamp_assembler`

## Requirements
- R1: The coarse counter is zero after reset and advances by one on every clock, wrapping modulo 2^CW.
- R2: While `coarse_clr` is high at a clock edge, the counter becomes zero on that edge and does not increment.
- R3: `coarse_wrap_o` is high for exactly the cycle that follows an edge at which the counter held all ones and `coarse_clr` was low, and is low at all other times.
- R4: A channel reports an event for a sample when its tap 0 differs from tap NTAP-1 of the previous sample on that channel (taken as 0 for the first sample after reset). The polarity flag equals tap 0: 1 for a rising edge, 0 for a falling edge.
- R5: The raw index is the lowest tap position i ≥ 1 whose value differs from tap 0, or NTAP when all taps are equal.
- R6: Each channel drives the raw index of its sample on its lookup address port and takes the fine value from its lookup data port one clock later, as from a memory with one cycle of read latency.
- R7: The timestamp equals coarse·2^13 − fine − deskew modulo 2^(CW+13), where coarse is the counter value during the cycle in which the taps were presented.
- R8: The event strobe is high for one cycle, with its outputs updated on the sixth clock edge, counting as the first the edge that samples the taps.
- R9: Channels are independent: an edge on one channel causes no strobe and no output change on another.
- R10: Polarity, timestamp and raw index outputs keep the values of the most recent event of their channel between strobes.
- R11: Synchronous reset clears every output to zero and clears all events in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_clr | input | 1 | Clears the coarse counter |
| taps_i | input | NCH*NTAP | Tap snapshot per channel, channel c at bits c*NTAP and up |
| deskew_i | input | NCH*(CW+13) | De-skew per channel, subtracted from the stamp |
| lut_addr_o | output | NCH*IDX_W | Lookup address (raw index) per channel |
| lut_data_i | input | NCH*13 | Lookup data per channel, valid one clock after its address |
| ev_stb_o | output | NCH | Event strobe per channel |
| ev_rise_o | output | NCH | Polarity per channel, 1 for rising |
| ev_ts_o | output | NCH*(CW+13) | Fixed-point timestamp per channel |
| ev_raw_o | output | NCH*IDX_W | Raw index per channel |
| coarse_wrap_o | output | 1 | Coarse counter wrap pulse |

## Verification
A wrong coarse count, whether off by one, cleared late or wrapped wrongly, shows six clocks later in the integer field of every stamp, and at once on the wrap pulse. A fault in the last-tap history or in the encoder shows at the next event on that channel as a missing or extra strobe, a wrong polarity or a wrong raw index. A lookup that is a cycle out of step only shows in the fraction. So the bench drives indices whose table entries differ widely, and it drives de-skews that make the stamp wrap below zero.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;
  // Width of the fractional part of every timestamp.
  localparam int FRAC_W = 13;
  // Clock edges from tap sampling to the strobe, sampling edge included.
  localparam int LATENCY = 6;
endpackage

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
  parameter int CW = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      wrap_o <= 1'b0;
    end else begin
      wrap_o <= (cnt_o == TOP) && !clr;
      cnt_o  <= clr ? '0 : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_tap_encoder.sv
module tdc_tap_encoder #(
  parameter int NTAP  = 400,
  parameter int IDX_W = $clog2(NTAP + 1)
) (
  input  logic [NTAP-1:0]  taps,
  output logic [IDX_W-1:0] idx
);
  // Lowest tap that disagrees with tap 0; NTAP when the whole line agrees.
  always_comb begin
    idx = IDX_W'(NTAP);
    for (int i = NTAP - 1; i >= 1; i--) begin
      if (taps[i] != taps[0]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tdc_channel_pipe.sv
module tdc_channel_pipe
  import tdc_stamp_pkg::*;
#(
  parameter int NTAP  = 400,
  parameter int CW    = 25,
  parameter int IDX_W = $clog2(NTAP + 1),
  parameter int TS_W  = CW + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NTAP-1:0]   taps_i,
  input  logic [CW-1:0]     coarse_i,
  input  logic [TS_W-1:0]   deskew_i,
  output logic [IDX_W-1:0]  lut_addr_o,
  input  logic [FRAC_W-1:0] lut_data_i,
  output logic              stb_o,
  output logic              rise_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [IDX_W-1:0]  raw_o
);
  // Stage 1: snapshot register
  logic [NTAP-1:0]   s1_taps;
  logic              s1_prev_last;
  logic [CW-1:0]     s1_coarse;
  // Stage 2: detection and encoding
  logic              s2_vld, s2_rise;
  logic [IDX_W-1:0]  s2_idx;
  logic [CW-1:0]     s2_coarse;
  // Stage 3: table read in progress
  logic              s3_vld, s3_rise;
  logic [IDX_W-1:0]  s3_idx;
  logic [CW-1:0]     s3_coarse;
  // Stage 4: fine value captured
  logic              s4_vld, s4_rise;
  logic [IDX_W-1:0]  s4_idx;
  logic [CW-1:0]     s4_coarse;
  logic [FRAC_W-1:0] s4_fine;
  // Stage 5: coarse minus fine
  logic              s5_vld, s5_rise;
  logic [IDX_W-1:0]  s5_idx;
  logic [TS_W-1:0]   s5_ts;

  logic [IDX_W-1:0]  enc_idx;

  tdc_tap_encoder #(.NTAP(NTAP), .IDX_W(IDX_W)) u_enc (
    .taps (s1_taps),
    .idx  (enc_idx)
  );

  assign lut_addr_o = s2_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_taps <= '0;  s1_prev_last <= 1'b0;  s1_coarse <= '0;
      s2_vld <= 1'b0; s2_rise <= 1'b0; s2_idx <= '0; s2_coarse <= '0;
      s3_vld <= 1'b0; s3_rise <= 1'b0; s3_idx <= '0; s3_coarse <= '0;
      s4_vld <= 1'b0; s4_rise <= 1'b0; s4_idx <= '0; s4_coarse <= '0;
      s4_fine <= '0;
      s5_vld <= 1'b0; s5_rise <= 1'b0; s5_idx <= '0; s5_ts <= '0;
      stb_o <= 1'b0;  rise_o <= 1'b0;  ts_o <= '0;   raw_o <= '0;
    end else begin
      s1_prev_last <= s1_taps[NTAP-1];
      s1_taps      <= taps_i;
      s1_coarse    <= coarse_i;

      s2_vld    <= s1_taps[0] ^ s1_prev_last;
      s2_rise   <= s1_taps[0];
      s2_idx    <= enc_idx;
      s2_coarse <= s1_coarse;

      s3_vld    <= s2_vld;
      s3_rise   <= s2_rise;
      s3_idx    <= s2_idx;
      s3_coarse <= s2_coarse;

      s4_vld    <= s3_vld;
      s4_rise   <= s3_rise;
      s4_idx    <= s3_idx;
      s4_coarse <= s3_coarse;
      s4_fine   <= lut_data_i;

      s5_vld  <= s4_vld;
      s5_rise <= s4_rise;
      s5_idx  <= s4_idx;
      s5_ts   <= {s4_coarse, {FRAC_W{1'b0}}} - TS_W'(s4_fine);

      stb_o <= s5_vld;
      if (s5_vld) begin
        rise_o <= s5_rise;
        ts_o   <= s5_ts - deskew_i;
        raw_o  <= s5_idx;
      end
    end
  end
endmodule

// File: rtl/tdc_stamp_assembler.sv
module tdc_stamp_assembler
  import tdc_stamp_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int NTAP  = 400,
  parameter  int CW    = 25,
  localparam int IDX_W = $clog2(NTAP + 1),
  localparam int TS_W  = CW + FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  coarse_clr,
  input  logic [NCH*NTAP-1:0]   taps_i,
  input  logic [NCH*TS_W-1:0]   deskew_i,
  output logic [NCH*IDX_W-1:0]  lut_addr_o,
  input  logic [NCH*FRAC_W-1:0] lut_data_i,
  output logic [NCH-1:0]        ev_stb_o,
  output logic [NCH-1:0]        ev_rise_o,
  output logic [NCH*TS_W-1:0]   ev_ts_o,
  output logic [NCH*IDX_W-1:0]  ev_raw_o,
  output logic                  coarse_wrap_o
);
  logic [CW-1:0] coarse_q;

  tdc_coarse_counter #(.CW(CW)) u_coarse (
    .clk    (clk),
    .rst    (rst),
    .clr    (coarse_clr),
    .cnt_o  (coarse_q),
    .wrap_o (coarse_wrap_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tdc_channel_pipe #(
      .NTAP (NTAP),
      .CW   (CW),
      .IDX_W(IDX_W),
      .TS_W (TS_W)
    ) u_pipe (
      .clk        (clk),
      .rst        (rst),
      .taps_i     (taps_i[c*NTAP +: NTAP]),
      .coarse_i   (coarse_q),
      .deskew_i   (deskew_i[c*TS_W +: TS_W]),
      .lut_addr_o (lut_addr_o[c*IDX_W +: IDX_W]),
      .lut_data_i (lut_data_i[c*FRAC_W +: FRAC_W]),
      .stb_o      (ev_stb_o[c]),
      .rise_o     (ev_rise_o[c]),
      .ts_o       (ev_ts_o[c*TS_W +: TS_W]),
      .raw_o      (ev_raw_o[c*IDX_W +: IDX_W])
    );
  end
endmodule

// File: rtl/tdc_stamp_checker.sv
module tdc_stamp_checker
  import tdc_stamp_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int NTAP  = 400,
  parameter  int CW    = 25,
  localparam int IDX_W = $clog2(NTAP + 1),
  localparam int TS_W  = CW + FRAC_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 coarse_clr,
  input logic [NCH*NTAP-1:0]  taps_i,
  input logic [NCH*IDX_W-1:0] lut_addr_o,
  input logic [NCH-1:0]       ev_stb_o,
  input logic [NCH-1:0]       ev_rise_o,
  input logic [NCH*TS_W-1:0]  ev_ts_o,
  input logic [NCH*IDX_W-1:0] ev_raw_o,
  input logic                 coarse_wrap_o,
  input logic [CW-1:0]        coarse_q
);
  localparam logic [CW-1:0] TOP = '1;

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    !coarse_clr |=> coarse_q == CW'($past(coarse_q) + 1'b1));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    coarse_clr |=> coarse_q == '0);

  p_wrap_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    coarse_wrap_o |-> ($past(coarse_q) == TOP) && !$past(coarse_clr) && coarse_q == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_polarity_r4: assert property (@(posedge clk) disable iff (rst)
      ev_stb_o[c] |-> ev_rise_o[c] == $past(taps_i[c*NTAP], 6));

    p_raw_path_r6: assert property (@(posedge clk) disable iff (rst)
      ev_stb_o[c] |-> ev_raw_o[c*IDX_W +: IDX_W] == $past(lut_addr_o[c*IDX_W +: IDX_W], 4));

    p_hold_ts_r10: assert property (@(posedge clk) disable iff (rst)
      !ev_stb_o[c] |-> $stable(ev_ts_o[c*TS_W +: TS_W]) && $stable(ev_rise_o[c]));
  end
endmodule

bind tdc_stamp_assembler tdc_stamp_checker #(
  .NCH (NCH),
  .NTAP(NTAP),
  .CW  (CW)
) u_stamp_check (
  .clk          (clk),
  .rst          (rst),
  .coarse_clr   (coarse_clr),
  .taps_i       (taps_i),
  .lut_addr_o   (lut_addr_o),
  .ev_stb_o     (ev_stb_o),
  .ev_rise_o    (ev_rise_o),
  .ev_ts_o      (ev_ts_o),
  .ev_raw_o     (ev_raw_o),
  .coarse_wrap_o(coarse_wrap_o),
  .coarse_q     (coarse_q)
);

// File: tb/tdc_stamp_assembler_bench.sv
module tdc_stamp_assembler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 2;
  localparam int NTAP  = 32;
  localparam int CW    = 8;
  localparam int FW    = 13;
  localparam int TS_W  = CW + FW;
  localparam int IDX_W = $clog2(NTAP + 1);
  localparam int CMAX  = (1 << CW) - 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 coarse_clr = 1'b0;
  logic [NCH*NTAP-1:0]  taps = '0;
  logic [NCH*TS_W-1:0]  deskew = '0;
  logic [NCH*IDX_W-1:0] lut_addr;
  logic [NCH*FW-1:0]    lut_data = '0;
  logic [NCH-1:0]       ev_stb;
  logic [NCH-1:0]       ev_rise;
  logic [NCH*TS_W-1:0]  ev_ts;
  logic [NCH*IDX_W-1:0] ev_raw;
  logic                 wrap;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  tdc_stamp_assembler #(.NCH(NCH), .NTAP(NTAP), .CW(CW)) u_tdc_stamp_assembler (
    .clk          (clk),
    .rst          (rst),
    .coarse_clr   (coarse_clr),
    .taps_i       (taps),
    .deskew_i     (deskew),
    .lut_addr_o   (lut_addr),
    .lut_data_i   (lut_data),
    .ev_stb_o     (ev_stb),
    .ev_rise_o    (ev_rise),
    .ev_ts_o      (ev_ts),
    .ev_raw_o     (ev_raw),
    .coarse_wrap_o(wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] table_fine(input logic [IDX_W-1:0] idx);
    return FW'((int'(idx) * 211 + 3) % 8192);
  endfunction

  // Calibration table with one clock of read latency (R6)
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      lut_data[c*FW +: FW] <= table_fine(lut_addr[c*FW/FW*IDX_W +: IDX_W]);
  end

  // Reference model
  bit               m_prev [NCH];
  int               m_cnt;
  int               edge_n;
  int               rd_slot;
  bit               m_ovf;
  bit               e_stb  [8][NCH];
  bit               e_rise [8][NCH];
  logic [TS_W-1:0]  e_ts   [8][NCH];
  logic [IDX_W-1:0] e_raw  [8][NCH];
  bit               h_rise [NCH];
  logic [TS_W-1:0]  h_ts   [NCH];
  logic [IDX_W-1:0] h_raw  [NCH];

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 8; s++)
        for (int c = 0; c < NCH; c++) begin
          e_stb[s][c] = 1'b0; e_rise[s][c] = 1'b0; e_ts[s][c] = '0; e_raw[s][c] = '0;
        end
      for (int c = 0; c < NCH; c++) begin
        m_prev[c] = 1'b0; h_rise[c] = 1'b0; h_ts[c] = '0; h_raw[c] = '0;
      end
      m_cnt = 0; m_ovf = 1'b0; edge_n = 0; rd_slot = 0;
    end else begin
      int slot;
      slot = (edge_n + 5) % 8;
      for (int c = 0; c < NCH; c++) begin
        logic [NTAP-1:0] t;
        int pos;
        t = taps[c*NTAP +: NTAP];
        e_stb[slot][c] = (t[0] != m_prev[c]);
        if (t[0] != m_prev[c]) begin
          pos = NTAP;
          for (int i = NTAP - 1; i >= 1; i--) if (t[i] != t[0]) pos = i;
          e_rise[slot][c] = t[0];
          e_raw[slot][c]  = IDX_W'(pos);
          e_ts[slot][c]   = (TS_W'(m_cnt) << FW) - TS_W'(table_fine(IDX_W'(pos)))
                            - deskew[c*TS_W +: TS_W];
        end
        m_prev[c] = t[NTAP-1];
      end
      m_ovf = (m_cnt == CMAX) && !coarse_clr;
      m_cnt = coarse_clr ? 0 : (m_cnt + 1) % (CMAX + 1);
      rd_slot = edge_n % 8;
      edge_n++;
    end
  end

  task automatic chk(input string tag, input int ch, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s ch%0d: actual %0h expected %0h at %0t", tag, ch, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R3 wrap pulse", 0, 64'(wrap), 64'(m_ovf));
      for (int c = 0; c < NCH; c++) begin
        if (e_stb[rd_slot][c]) begin
          h_rise[c] = e_rise[rd_slot][c];
          h_ts[c]   = e_ts[rd_slot][c];
          h_raw[c]  = e_raw[rd_slot][c];
          chk("R8 strobe at sixth edge", c, 64'(ev_stb[c]), 64'(1));
        end else begin
          chk(rst ? "R11 reset strobe" : "R9 no strobe without edge", c, 64'(ev_stb[c]), 64'(0));
        end
        chk("R4 polarity / R10 hold", c, 64'(ev_rise[c]), 64'(h_rise[c]));
        chk("R7 stamp (coarse R1 R2) / R10 hold", c, 64'(ev_ts[c*TS_W +: TS_W]), 64'(h_ts[c]));
        chk("R5 raw index / R6 lookup / R11", c, 64'(ev_raw[c*IDX_W +: IDX_W]), 64'(h_raw[c]));
      end
    end
  end

  // Stimulus
  bit lvl [NCH];
  logic [15:0] lf = 16'hACE1;

  function automatic int next_pos();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return int'(lf % NTAP) + 1;
  endfunction

  // p > 0 places an edge whose first stale tap is p; 0 keeps the level.
  task automatic run_cycle(input int p0, input int p1);
    int p [NCH];
    p[0] = p0; p[1] = p1;
    for (int c = 0; c < NCH; c++) begin
      bit nl;
      nl = (p[c] > 0) ? !lvl[c] : lvl[c];
      for (int i = 0; i < NTAP; i++)
        taps[c*NTAP + i] = (p[c] > 0 && i >= p[c]) ? lvl[c] : nl;
      lvl[c] = nl;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) lvl[c] = 1'b0;
    deskew[0 +: TS_W]    = TS_W'(100);
    deskew[TS_W +: TS_W] = TS_W'((1 << TS_W) - 50);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) run_cycle(0, 0);
    // Index corners: first tap, whole line, middle, both channels at once
    run_cycle(1, 0);      run_cycle(0, 0);
    run_cycle(NTAP, NTAP); run_cycle(0, 0);
    run_cycle(NTAP/2, 0); run_cycle(0, 1);  run_cycle(0, 0);
    for (int k = 0; k < 400; k++) begin
      coarse_clr = (k == 150);
      run_cycle((k % 3 == 0) ? next_pos() : 0, (k % 5 == 2) ? next_pos() : 0);
    end
    coarse_clr = 1'b0;
    repeat (8) run_cycle(0, 0);
    deskew[0 +: TS_W]    = '0;
    deskew[TS_W +: TS_W] = TS_W'(5000);
    for (int k = 0; k < 300; k++)
      run_cycle((k % 2 == 0) ? next_pos() : 0, (k % 7 == 3) ? next_pos() : 0);
    // Reset in the middle of activity
    run_cycle(5, 7);
    rst = 1'b1;
    for (int c = 0; c < NCH; c++) lvl[c] = 1'b0;
    taps = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) run_cycle(0, 0);
    for (int k = 0; k < 20; k++)
      run_cycle((k % 3 == 1) ? next_pos() : 0, (k % 4 == 0) ? next_pos() : 0);
    repeat (10) run_cycle(0, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule